// File: doc/BRIEF.md
# Integer ALU with condition codes

This block is the integer execution unit of a 32-bit byte-addressable core. Each clock edge with `opValid` high applies one operation to a source operand, a destination operand and an 8-bit short literal. The operations are add, subtract, literal-add, carry-chained add, negate, borrow-chained negate, zero, sign extension, half swap, plain copy, address copy and literal load. Operand size may be byte, word or long. The result register and the status register update on that edge.

The status register holds a system byte above a flag byte. The flag byte carries an extend flag X for multiprecision chains, plus N, Z, V and C. Each operation has its own rule for which flags it writes. Software can load the flag byte at any time. Loading the whole status register needs supervisor mode. A user-mode attempt changes nothing and raises a one-cycle fault pulse. Address generation, memory access, multiply, divide and instruction decoding lie outside this block.

Top module: `intAluCc`

## Requirements
- R1: Outputs are registered and change only on a clock edge where `opValid` is high; the effect of an operation is visible right after that edge. When `opValid` is low, `result`, `statusReg` and `privFault` hold (with `privFault` going low). After reset, `result`=0, `statusReg`=0 and `privFault`=0. Size codes: 0 byte, 1 word, 2 and 3 long. Flag positions in `statusReg`: C bit 0, V bit 1, Z bit 2, N bit 3, X bit 4; bits 7:5 read zero and bits 15:8 are the system byte.
- R2: Copy (opCode 0) writes the low 8, 16 or 32 bits of `srcOp` over the same bits of `dstOp`. The upper bits keep their `dstOp` value, and the same merge holds for every sized operation. N and Z come from the sized value, V and C are cleared, and X is kept.
- R3: Address copy (opCode 1) returns all 32 bits of `srcOp` whatever the size code, and leaves every flag unchanged.
- R4: Add (opCode 2) computes dst+src and subtract (opCode 5) computes dst-src, at the selected size. C is the carry or borrow out of that size's top bit, and X takes the same value. V is signed overflow, and N and Z are taken at that size.
- R5: Literal-add (opCode 3) adds a literal from 1 to 8 to dst, taken from `quickImm[2:0]`, where 0 stands for 8. `quickImm[7:3]` is ignored. Flags follow the add rule.
- R6: Chained add (opCode 4) computes dst+src+X, with X and C set to the carry out and V, N set as for add. Z is cleared when the sized result is nonzero; otherwise Z keeps its previous value.
- R7: Negate (opCode 6) computes 0-dst, and chained negate (opCode 7) computes 0-dst-X. C and X take the borrow, and V and N are set at size. Negate sets Z from the result. Chained negate clears Z on a nonzero result and otherwise keeps it.
- R8: Zero (opCode 8) writes zero at the selected size. It sets N=0, Z=1, V=0 and C=0, and keeps X.
- R9: Sign extension (opCode 9) works in two ways. With size 0 or 1 it copies bit 7 into bits 15:8 and keeps bits 31:16, with N and Z taken at word size. With size 2 or 3 it copies bit 15 into bits 31:16, with N and Z taken at long size. Both forms clear V and C and keep X.
- R10: Half swap (opCode 10) exchanges bits 31:16 and 15:0 of dst whatever the size code. N is taken from bit 31 and Z from all 32 bits, V and C are cleared, and X is kept.
- R11: Literal load (opCode 11) returns `quickImm` sign-extended to 32 bits whatever the size code (for example 0xFD gives 0xFFFFFFFD). N and Z are taken at long size, V and C are cleared, and X is kept.
- R12: Flag write (opCode 12) loads `srcOp[4:0]` into the flag bits in either mode. Bits 15:8 and `result` stay unchanged.
- R13: Status write (opCode 13) in supervisor mode loads bits 15:8 from `srcOp[15:8]` and the flags from `srcOp[4:0]`. In user mode it leaves `statusReg` unchanged and sets `privFault` for exactly one cycle. Status read (opCode 14) returns `{dstOp[31:16], statusReg}` in either mode and keeps the flags.
- R14: OpCode 15 changes neither `result` nor `statusReg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Apply the presented operation on this edge |
| opCode | input | 4 | Operation selector (see requirements) |
| opSize | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| srcOp | input | 32 | Source operand |
| dstOp | input | 32 | Destination operand |
| quickImm | input | 8 | Short literal for literal-add and literal load |
| superMode | input | 1 | High when executing in supervisor mode |
| result | output | 32 | Registered result |
| statusReg | output | 16 | System byte and flag byte |
| privFault | output | 1 | One-cycle pulse after a user-mode status write |

## Verification
The case where two functions fall in the same cycle is a carry-chained operation whose own flag update lands on the same edge that reads the X and Z left by the operation just before it. The directed part builds this case on purpose. It issues back-to-back chained adds after a flag write has set Z, first with X clear and then with X produced by a wrapping add. The Z flag must survive a zero piece and fall on a nonzero one. A random phase then issues operations on every cycle. A behavioural model computes the flags with wide signed integers and checks `result`, `statusReg` and `privFault` on every clock, so any stale or early flag read shows up at once.

// File: rtl/intAluPkg.sv
package intAluPkg;

  typedef enum logic [3:0] {
    OP_COPY      = 4'd0,
    OP_COPYADDR  = 4'd1,
    OP_ADD       = 4'd2,
    OP_ADDLIT    = 4'd3,
    OP_ADDCHAIN  = 4'd4,
    OP_SUB       = 4'd5,
    OP_NEG       = 4'd6,
    OP_NEGCHAIN  = 4'd7,
    OP_ZERO      = 4'd8,
    OP_SEXT      = 4'd9,
    OP_HALFSWAP  = 4'd10,
    OP_LOADLIT   = 4'd11,
    OP_SETFLAGS  = 4'd12,
    OP_SETSTATUS = 4'd13,
    OP_GETSTATUS = 4'd14,
    OP_IDLE      = 4'd15
  } aluOpE;

  typedef enum logic [1:0] {
    FL_KEEP  = 2'd0,
    FL_LOGIC = 2'd1,
    FL_ARITH = 2'd2,
    FL_CHAIN = 2'd3
  } flagModeE;

  typedef enum logic [3:0] {
    RS_KEEP    = 4'd0,
    RS_ARITH   = 4'd1,
    RS_MOVE    = 4'd2,
    RS_ZERO    = 4'd3,
    RS_SEXT    = 4'd4,
    RS_SWAP    = 4'd5,
    RS_LIT     = 4'd6,
    RS_FULLSRC = 4'd7,
    RS_STATUS  = 4'd8
  } resSelE;

  typedef struct packed {
    resSelE   resSel;
    flagModeE flagMode;
    logic     subtract;
    logic     useX;
    logic     litOperand;
    logic     negate;
    logic     wrCcr;
    logic     wrSys;
  } ctrlStrobesT;

  localparam int FLAG_C = 0;
  localparam int FLAG_V = 1;
  localparam int FLAG_Z = 2;
  localparam int FLAG_N = 3;
  localparam int FLAG_X = 4;
  localparam int CCR_W  = 5;

endpackage

// File: rtl/intAluCtrl.sv
module intAluCtrl
  import intAluPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [3:0]  opCode,
  input  logic        superMode,
  output ctrlStrobesT ctrl,
  output logic        privFault
);

  logic faultNow;

  always_comb begin
    ctrl.resSel     = RS_KEEP;
    ctrl.flagMode   = FL_KEEP;
    ctrl.subtract   = 1'b0;
    ctrl.useX       = 1'b0;
    ctrl.litOperand = 1'b0;
    ctrl.negate     = 1'b0;
    ctrl.wrCcr      = 1'b0;
    ctrl.wrSys      = 1'b0;
    faultNow        = 1'b0;
    if (opValid) begin
      unique case (aluOpE'(opCode))
        OP_COPY: begin
          ctrl.resSel   = RS_MOVE;
          ctrl.flagMode = FL_LOGIC;
        end
        OP_COPYADDR: ctrl.resSel = RS_FULLSRC;
        OP_ADD: begin
          ctrl.resSel   = RS_ARITH;
          ctrl.flagMode = FL_ARITH;
        end
        OP_ADDLIT: begin
          ctrl.resSel     = RS_ARITH;
          ctrl.flagMode   = FL_ARITH;
          ctrl.litOperand = 1'b1;
        end
        OP_ADDCHAIN: begin
          ctrl.resSel   = RS_ARITH;
          ctrl.flagMode = FL_CHAIN;
          ctrl.useX     = 1'b1;
        end
        OP_SUB: begin
          ctrl.resSel   = RS_ARITH;
          ctrl.flagMode = FL_ARITH;
          ctrl.subtract = 1'b1;
        end
        OP_NEG: begin
          ctrl.resSel   = RS_ARITH;
          ctrl.flagMode = FL_ARITH;
          ctrl.subtract = 1'b1;
          ctrl.negate   = 1'b1;
        end
        OP_NEGCHAIN: begin
          ctrl.resSel   = RS_ARITH;
          ctrl.flagMode = FL_CHAIN;
          ctrl.subtract = 1'b1;
          ctrl.negate   = 1'b1;
          ctrl.useX     = 1'b1;
        end
        OP_ZERO: begin
          ctrl.resSel   = RS_ZERO;
          ctrl.flagMode = FL_LOGIC;
        end
        OP_SEXT: begin
          ctrl.resSel   = RS_SEXT;
          ctrl.flagMode = FL_LOGIC;
        end
        OP_HALFSWAP: begin
          ctrl.resSel   = RS_SWAP;
          ctrl.flagMode = FL_LOGIC;
        end
        OP_LOADLIT: begin
          ctrl.resSel   = RS_LIT;
          ctrl.flagMode = FL_LOGIC;
        end
        OP_SETFLAGS:  ctrl.wrCcr = 1'b1;
        OP_SETSTATUS: begin
          ctrl.wrSys = superMode;
          faultNow   = !superMode;
        end
        OP_GETSTATUS: ctrl.resSel = RS_STATUS;
        OP_IDLE: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) privFault <= 1'b0;
    else       privFault <= faultNow;
  end

endmodule

// File: rtl/intAluDatapath.sv
module intAluDatapath
  import intAluPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LIT_W   = 8,
  parameter int QUICK_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       ctrl,
  input  logic [1:0]        opSize,
  input  logic [DATA_W-1:0] srcOp,
  input  logic [DATA_W-1:0] dstOp,
  input  logic [LIT_W-1:0]  quickImm,
  output logic [DATA_W-1:0] result,
  output logic [15:0]       statusReg
);

  localparam int BYTE_W  = 8;
  localparam int HALF_W  = DATA_W / 2;
  localparam int SYS_W   = 8;
  localparam int N_SIZES = 3;
  localparam int PAD_W   = 8 - CCR_W;

  logic [DATA_W-1:0] resultQ;
  logic [SYS_W-1:0]  sysQ;
  logic [CCR_W-1:0]  ccrQ, ccrNext;
  logic [SYS_W-1:0]  sysNext;

  logic [1:0]        szIdx, fIdx;
  logic [DATA_W-1:0] opA, opB, quickVal, litVal, sized, resNext;
  logic              cin, nVal, zVal;

  logic [DATA_W-1:0] sumBy [N_SIZES];
  logic [N_SIZES-1:0] carryBy, ovfBy;

  function automatic logic [DATA_W-1:0] maskOf(input logic [1:0] idx);
    case (idx)
      2'd0:    maskOf = DATA_W'({BYTE_W{1'b1}});
      2'd1:    maskOf = DATA_W'({HALF_W{1'b1}});
      default: maskOf = '1;
    endcase
  endfunction

  function automatic logic msbOf(input logic [DATA_W-1:0] val, input logic [1:0] idx);
    case (idx)
      2'd0:    msbOf = val[BYTE_W-1];
      2'd1:    msbOf = val[HALF_W-1];
      default: msbOf = val[DATA_W-1];
    endcase
  endfunction

  assign szIdx    = (opSize == 2'd3) ? 2'd2 : opSize;
  assign quickVal = (quickImm[QUICK_W-1:0] == '0) ? DATA_W'(1 << QUICK_W)
                                                   : DATA_W'(quickImm[QUICK_W-1:0]);
  assign litVal   = {{(DATA_W-LIT_W){quickImm[LIT_W-1]}}, quickImm};
  assign opA      = ctrl.negate ? '0 : dstOp;
  assign opB      = ctrl.litOperand ? quickVal : (ctrl.negate ? dstOp : srcOp);
  assign cin      = ctrl.useX & ccrQ[FLAG_X];

  // one adder/subtractor slice per operand size
  for (genvar g = 0; g < N_SIZES; g++) begin : gSize
    localparam int W = BYTE_W << g;
    logic [W-1:0] aS, bS;
    logic [W:0]   cinW, raw;
    assign aS   = opA[W-1:0];
    assign bS   = opB[W-1:0];
    assign cinW = {{W{1'b0}}, cin};
    assign raw  = ctrl.subtract ? ({1'b0, aS} - {1'b0, bS} - cinW)
                                : ({1'b0, aS} + {1'b0, bS} + cinW);
    assign sumBy[g]   = DATA_W'(raw[W-1:0]);
    assign carryBy[g] = raw[W];
    assign ovfBy[g]   = (raw[W-1] != aS[W-1]) &&
                        (ctrl.subtract ? (aS[W-1] != bS[W-1]) : (aS[W-1] == bS[W-1]));
  end

  always_comb begin
    fIdx  = szIdx;
    sized = '0;
    unique case (ctrl.resSel)
      RS_ARITH:   sized = sumBy[szIdx];
      RS_MOVE:    sized = srcOp & maskOf(szIdx);
      RS_ZERO:    sized = '0;
      RS_SEXT: begin
        if (szIdx == 2'd2) begin
          fIdx  = 2'd2;
          sized = {{HALF_W{dstOp[HALF_W-1]}}, dstOp[HALF_W-1:0]};
        end else begin
          fIdx  = 2'd1;
          sized = DATA_W'({{BYTE_W{dstOp[BYTE_W-1]}}, dstOp[BYTE_W-1:0]});
        end
      end
      RS_SWAP: begin
        fIdx  = 2'd2;
        sized = {dstOp[HALF_W-1:0], dstOp[DATA_W-1:HALF_W]};
      end
      RS_LIT: begin
        fIdx  = 2'd2;
        sized = litVal;
      end
      RS_FULLSRC: begin
        fIdx  = 2'd2;
        sized = srcOp;
      end
      RS_STATUS: begin
        fIdx  = 2'd1;
        sized = DATA_W'(statusReg);
      end
      default: ;
    endcase
    resNext = (ctrl.resSel == RS_KEEP) ? resultQ : ((dstOp & ~maskOf(fIdx)) | sized);
  end

  assign nVal = msbOf(sized, fIdx);
  assign zVal = ((sized & maskOf(fIdx)) == '0);

  always_comb begin
    ccrNext = ccrQ;
    sysNext = sysQ;
    unique case (ctrl.flagMode)
      FL_LOGIC: begin
        ccrNext[FLAG_N] = nVal;
        ccrNext[FLAG_Z] = zVal;
        ccrNext[FLAG_V] = 1'b0;
        ccrNext[FLAG_C] = 1'b0;
      end
      FL_ARITH, FL_CHAIN: begin
        ccrNext[FLAG_X] = carryBy[szIdx];
        ccrNext[FLAG_C] = carryBy[szIdx];
        ccrNext[FLAG_V] = ovfBy[szIdx];
        ccrNext[FLAG_N] = nVal;
        ccrNext[FLAG_Z] = (ctrl.flagMode == FL_CHAIN) ? (ccrQ[FLAG_Z] & zVal) : zVal;
      end
      default: ;
    endcase
    if (ctrl.wrCcr || ctrl.wrSys) ccrNext = srcOp[CCR_W-1:0];
    if (ctrl.wrSys) sysNext = srcOp[2*SYS_W-1:SYS_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      ccrQ    <= '0;
      sysQ    <= '0;
    end else begin
      resultQ <= resNext;
      ccrQ    <= ccrNext;
      sysQ    <= sysNext;
    end
  end

  assign result    = resultQ;
  assign statusReg = {sysQ, {PAD_W{1'b0}}, ccrQ};

endmodule

// File: rtl/intAluCc.sv
module intAluCc
  import intAluPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LIT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [1:0]        opSize,
  input  logic [DATA_W-1:0] srcOp,
  input  logic [DATA_W-1:0] dstOp,
  input  logic [LIT_W-1:0]  quickImm,
  input  logic              superMode,
  output logic [DATA_W-1:0] result,
  output logic [15:0]       statusReg,
  output logic              privFault
);

  ctrlStrobesT ctrl;

  intAluCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .opCode    (opCode),
    .superMode (superMode),
    .ctrl      (ctrl),
    .privFault (privFault)
  );

  intAluDatapath #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .opSize    (opSize),
    .srcOp     (srcOp),
    .dstOp     (dstOp),
    .quickImm  (quickImm),
    .result    (result),
    .statusReg (statusReg)
  );

endmodule

// File: rtl/intAluCcChk.sv
module intAluCcChk (
  input logic        clk,
  input logic        rstN,
  input logic        opValid,
  input logic [3:0]  opCode,
  input logic [7:0]  quickImm,
  input logic        superMode,
  input logic [31:0] result,
  input logic [15:0] statusReg,
  input logic        privFault
);

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(opValid)) |-> ($stable(result) && $stable(statusReg) && !privFault)) // R1
    else $error("idle cycle changed state");

  AST_COPY_CLEARS_VC: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opValid) && $past(opCode) == 4'd0) |-> (statusReg[1:0] == 2'b00)) // R2
    else $error("copy left V or C set");

  AST_COPYADDR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opValid) && $past(opCode) == 4'd1) |-> (statusReg == $past(statusReg))) // R3
    else $error("address copy touched flags");

  AST_ZERO_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opValid) && $past(opCode) == 4'd8) |-> (statusReg[3:0] == 4'b0100)) // R8
    else $error("zero op flags wrong");

  AST_LOADLIT_SEXT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opValid) && $past(opCode) == 4'd11) |->
      (result == {{24{$past(quickImm[7])}}, $past(quickImm)})) // R11
    else $error("literal load not sign-extended");

  AST_FLAGWRITE_KEEPS_SYS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opValid) && $past(opCode) == 4'd12) |-> (statusReg[15:8] == $past(statusReg[15:8]))) // R12
    else $error("flag write changed system byte");

  AST_FAULT_ONLY_USER: assert property (@(posedge clk) disable iff (!rstN)
    privFault |-> ($past(rstN) && $past(opValid) && $past(opCode) == 4'd13 && !$past(superMode))) // R13
    else $error("fault without user status write");

  AST_FAULT_STATUS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    privFault |-> (statusReg == $past(statusReg))) // R13
    else $error("status changed on faulting write");

endmodule

bind intAluCc intAluCcChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opCode    (opCode),
  .quickImm  (quickImm),
  .superMode (superMode),
  .result    (result),
  .statusReg (statusReg),
  .privFault (privFault)
);

// File: tb/intAluCc_tb.sv
`timescale 1ns/1ps
module intAluCc_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [1:0]  opSize = '0;
  logic [31:0] srcOp = '0, dstOp = '0;
  logic [7:0]  quickImm = '0;
  logic        superMode = 1'b0;
  logic [31:0] result;
  logic [15:0] statusReg;
  logic        privFault;

  int    errors = 0;
  int    checks = 0;
  bit    finished = 1'b0;
  bit    compareOn = 1'b0;

  logic [31:0] mRes;
  logic [15:0] mSr;
  logic        mFault;
  string       tagQ = "R1";

  always #4 clk = ~clk;

  intAluCc u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opSize(opSize),
    .srcOp(srcOp), .dstOp(dstOp), .quickImm(quickImm), .superMode(superMode),
    .result(result), .statusReg(statusReg), .privFault(privFault)
  );

  function automatic string reqOf(input logic [3:0] code);
    case (code)
      4'd0: return "R2";   4'd1: return "R3";   4'd2: return "R4";
      4'd3: return "R5";   4'd4: return "R6";   4'd5: return "R4";
      4'd6: return "R7";   4'd7: return "R7";   4'd8: return "R8";
      4'd9: return "R9";   4'd10: return "R10"; 4'd11: return "R11";
      4'd12: return "R12"; 4'd13: return "R13"; 4'd14: return "R13";
      default: return "R14";
    endcase
  endfunction

  function automatic longint sgnOf(input longint v, input int w);
    return (v >= (longint'(1) << (w - 1))) ? v - (longint'(1) << w) : v;
  endfunction

  function automatic logic [31:0] mergeIt(input logic [31:0] d, input longint r, input int w);
    longint m = (longint'(1) << w) - 1;
    longint full = (longint'(d) & ~m) | (r & m);
    return full[31:0];
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference, one step per clock
  always @(posedge clk) begin
    if (!rstN) begin
      mRes = '0; mSr = '0; mFault = 1'b0; tagQ = "R1";
    end else begin
      mFault = 1'b0;
      tagQ = opValid ? reqOf(opCode) : "R1";
      if (opValid) begin
        int w; longint m, a, b, full, r, sv, half; bit x, n, z, v, c, cin;
        x = mSr[4]; n = mSr[3]; z = mSr[2]; v = mSr[1]; c = mSr[0];
        w = (opSize == 2'd0) ? 8 : (opSize == 2'd1) ? 16 : 32;
        m = (longint'(1) << w) - 1;
        r = 0;
        case (opCode)
          4'd0: begin r = longint'(srcOp) & m; v = 0; c = 0; end
          4'd2, 4'd3, 4'd4: begin
            a = longint'(dstOp) & m;
            b = (opCode == 4'd3) ? ((quickImm[2:0] == 0) ? 8 : longint'(quickImm[2:0])) : (longint'(srcOp) & m);
            cin = (opCode == 4'd4) ? x : 1'b0;
            full = a + b + cin;
            sv = sgnOf(a, w) + sgnOf(b, w) + cin;
          end
          4'd5, 4'd6, 4'd7: begin
            a = (opCode == 4'd5) ? (longint'(dstOp) & m) : 0;
            b = (opCode == 4'd5) ? (longint'(srcOp) & m) : (longint'(dstOp) & m);
            cin = (opCode == 4'd7) ? x : 1'b0;
            full = a - b - cin;
            sv = sgnOf(a, w) - sgnOf(b, w) - cin;
          end
          4'd8: begin r = 0; v = 0; c = 0; end
          4'd9: begin
            if (w == 32) r = dstOp[15] ? (longint'(dstOp[15:0]) | 64'hFFFF0000) : longint'(dstOp[15:0]);
            else begin w = 16; r = dstOp[7] ? (longint'(dstOp[7:0]) | 64'hFF00) : longint'(dstOp[7:0]); end
            v = 0; c = 0;
          end
          4'd10: begin w = 32; r = longint'({dstOp[15:0], dstOp[31:16]}); v = 0; c = 0; end
          4'd11: begin w = 32; r = longint'($signed(quickImm)) & 64'hFFFFFFFF; v = 0; c = 0; end
          default: ;
        endcase
        m = (longint'(1) << w) - 1;
        half = longint'(1) << (w - 1);
        if (opCode inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7}) begin
          r = full & m;
          c = (opCode inside {4'd2, 4'd3, 4'd4}) ? ((full >> w) & 1) != 0 : (full < 0);
          x = c;
          v = (sv > half - 1) || (sv < -half);
        end
        if (opCode inside {4'd0, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11}) begin
          n = ((r >> (w - 1)) & 1) != 0;
          if (opCode == 4'd4 || opCode == 4'd7) z = z && (r == 0);
          else z = (r == 0);
          mRes = mergeIt(dstOp, r, w);
          mSr[4:0] = {x, n, z, v, c};
        end
        case (opCode)
          4'd1:  mRes = srcOp;
          4'd12: mSr[4:0] = srcOp[4:0];
          4'd13: if (superMode) mSr = {srcOp[15:8], 3'b000, srcOp[4:0]}; else mFault = 1'b1;
          4'd14: mRes = {dstOp[31:16], mSr};
          default: ;
        endcase
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (compareOn && !finished) begin
      check(tagQ, "result", result, mRes);
      check(tagQ, "statusReg", statusReg, mSr);
      check(tagQ, "privFault", privFault, mFault);
    end
  end

  task automatic doOp(input logic [3:0] code, input logic [1:0] sz, input logic [31:0] s,
                      input logic [31:0] d, input logic [7:0] imm, input logic sup);
    @(negedge clk);
    opValid = 1'b1; opCode = code; opSize = sz; srcOp = s; dstOp = d;
    quickImm = imm; superMode = sup;
  endtask

  task automatic expectNext(input string tag, input logic [31:0] expRes, input logic [15:0] expSr);
    @(negedge clk);
    opValid = 1'b0;
    check(tag, "directed result", result, expRes);
    check(tag, "directed status", statusReg, expSr);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R1", "reset result", result, 0);
    check("R1", "reset status", statusReg, 0);
    check("R1", "reset fault", privFault, 0);
    compareOn = 1'b1;
    // R1: idle cycles change nothing
    @(negedge clk); @(negedge clk);

    doOp(4'd0, 2'd0, 32'h0000_0080, 32'h1122_3344, 8'h00, 1'b0);      // R2 byte copy, N
    expectNext("R2", 32'h1122_3380, 16'h0008);
    doOp(4'd0, 2'd1, 32'hFFFF_0000, 32'hAAAA_5555, 8'h00, 1'b0);      // R2 word zero
    doOp(4'd12, 2'd0, 32'h0000_001F, 32'h0, 8'h00, 1'b0);             // R12 all flags
    doOp(4'd1, 2'd0, 32'hDEAD_BEEF, 32'h0, 8'h00, 1'b0);              // R3
    expectNext("R3", 32'hDEAD_BEEF, 16'h001F);
    doOp(4'd2, 2'd0, 32'h0000_0001, 32'h1234_56FF, 8'h00, 1'b0);      // R4 byte carry
    expectNext("R4", 32'h1234_5600, 16'h0015);
    doOp(4'd2, 2'd1, 32'h0000_0001, 32'h0000_7FFF, 8'h00, 1'b0);      // R4 word overflow
    doOp(4'd2, 2'd2, 32'h8000_0000, 32'h8000_0000, 8'h00, 1'b0);      // R4 long carry+V
    doOp(4'd5, 2'd0, 32'h0000_0001, 32'h0000_0000, 8'h00, 1'b0);      // R4 byte borrow
    doOp(4'd5, 2'd2, 32'h0000_0001, 32'h8000_0000, 8'h00, 1'b0);      // R4 long V
    doOp(4'd3, 2'd2, 32'h0, 32'h0000_0010, 8'h00, 1'b0);              // R5 literal 8
    expectNext("R5", 32'h0000_0018, 16'h0000);
    doOp(4'd3, 2'd0, 32'h0, 32'h0000_00FE, 8'hF3, 1'b0);              // R5 high bits ignored
    doOp(4'd12, 2'd0, 32'h0000_0004, 32'h0, 8'h00, 1'b0);             // Z set, X clear
    doOp(4'd4, 2'd2, 32'h0000_0001, 32'hFFFF_FFFF, 8'h00, 1'b0);      // R6 zero piece, X out
    expectNext("R6", 32'h0000_0000, 16'h0015);
    doOp(4'd4, 2'd2, 32'h0, 32'h0, 8'h00, 1'b0);                      // R6 consumes X
    doOp(4'd4, 2'd2, 32'h0, 32'h0, 8'h00, 1'b0);                      // R6 Z stays clear
    doOp(4'd6, 2'd0, 32'h0, 32'h0000_0001, 8'h00, 1'b0);              // R7 neg byte
    doOp(4'd6, 2'd1, 32'h0, 32'h0000_8000, 8'h00, 1'b0);              // R7 neg overflow
    doOp(4'd6, 2'd2, 32'h0, 32'h0, 8'h00, 1'b0);                      // R7 neg zero
    doOp(4'd12, 2'd0, 32'h0000_0014, 32'h0, 8'h00, 1'b0);
    doOp(4'd7, 2'd2, 32'h0, 32'h0, 8'h00, 1'b0);                      // R7 chained neg
    expectNext("R7", 32'hFFFF_FFFF, 16'h0019);
    doOp(4'd8, 2'd1, 32'h0, 32'h1234_5678, 8'h00, 1'b0);              // R8
    doOp(4'd9, 2'd1, 32'h0, 32'h1234_0080, 8'h00, 1'b0);              // R9 byte to word
    expectNext("R9", 32'h1234_FF80, 16'h0018);
    doOp(4'd9, 2'd2, 32'h0, 32'h0000_8000, 8'h00, 1'b0);              // R9 word to long
    doOp(4'd10, 2'd0, 32'h0, 32'h8765_4321, 8'h00, 1'b0);             // R10
    expectNext("R10", 32'h4321_8765, 16'h0010);
    doOp(4'd11, 2'd0, 32'h0, 32'h0, 8'hFD, 1'b0);                     // R11
    expectNext("R11", 32'hFFFF_FFFD, 16'h0018);
    doOp(4'd11, 2'd1, 32'h0, 32'hFFFF_FFFF, 8'h7F, 1'b0);             // R11
    doOp(4'd13, 2'd0, 32'h0000_A51F, 32'h0, 8'h00, 1'b0);             // R13 user: fault
    doOp(4'd13, 2'd0, 32'h0000_A51F, 32'h0, 8'h00, 1'b1);             // R13 supervisor
    doOp(4'd12, 2'd0, 32'hFFFF_FF00, 32'h0, 8'h00, 1'b0);             // R12 sys kept
    doOp(4'd14, 2'd0, 32'h0, 32'hBEEF_0000, 8'h00, 1'b0);             // R13 read
    expectNext("R13", 32'hBEEF_A500, 16'hA500);
    doOp(4'd15, 2'd2, 32'hFFFF_FFFF, 32'h1234_5678, 8'hFF, 1'b1);     // R14
    expectNext("R14", 32'hBEEF_A500, 16'hA500);

    for (int i = 0; i < 600; i++) begin
      doOp(4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), $urandom, $urandom,
           8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
    end
    @(negedge clk);
    opValid = 1'b0;
    @(negedge clk); @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule